// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block places incoming receive frames into a circular buffer in memory that is divided into 256-byte pages. The ring is bounded by a configurable first page and an end page that is never written itself. Frames arrive as a byte stream. Each frame starts on a page boundary. Four header bytes at the start of the page are left free for a descriptor, and the frame bytes follow them. The block owns the write page pointer. Software owns the read page pointer and drives it in. Writing stops when the write address reaches the start of the read page.

When the last byte of a frame has been accepted, the block does the following:
- It rounds the write page pointer up to the next page.
- If the buffer filled during the frame and recovery is enabled, it rolls the pointer back to the frame's first page.
- It stores a descriptor at the frame's first page. The descriptor holds the following page, the stored length and a status byte.
- It copies that status byte to a last-status output.
- It raises sticky interrupt flags, each gated by its own mask input.

The memory side is a single byte-wide write port.

Top module: `rxring_writer`

## Requirements
- R1: After reset, the following hold: `wr_page_o` is 0, `last_status_o` is 0, both interrupt flags are 0, `in_ready_o` is 1 and `mem_we_o` is 0.
- R2: A `ptr_init_i` pulse while no frame is in progress loads the write page pointer with `start_page_i`.
- R3: Byte i of a frame (i counting from 0) is written at byte address page*256+offset. The write starts at offset 4 of the current write page, and the address steps by one for each byte. After offset 255 the page advances by one. When the advanced page equals `end_page_i`, the page becomes `start_page_i` instead.
- R4: When a written byte moves the address to offset 0 of page `rd_page_i`, no further bytes of that frame are written. The status gains frame-overflow (bit 1) and buffer-full (bit 2). If `imask_bf_i` is 1, `irq_bf_o` is set.
- R5: After the last byte, the write page advances once more (with the same wrap) when (frame length + 4) mod 256 is not 0.
- R6: If the frame overflowed and `auto_recover_i` is 1, the write page pointer returns to the page the frame started on.
- R7: Status bit 0 is set when bit 0 of the first frame byte is 1 (multicast).
- R8: After the frame, bytes 0..3 of the frame's first page receive a 32-bit little-endian word. Bits 11:0 hold the new write page, bits 23:12 hold (frame length + 4) mod 4096, and bits 31:24 hold the status. `in_ready_o` stays 0 from the cycle after the last byte until the descriptor has been written.
- R9: Once the descriptor is written, `last_status_o` shows the frame's status. `irq_rx_o` is set only if `imask_rx_i` is 1.
- R10: A 1 on `irq_clr_i[0]` clears `irq_rx_o`, and a 1 on `irq_clr_i[1]` clears `irq_bf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Frame byte valid |
| in_data_i | input | 8 | Frame byte |
| in_last_i | input | 1 | Marks final byte of frame |
| in_ready_o | output | 1 | Byte accepted when high with valid |
| start_page_i | input | PAGE_W | First page of the ring |
| end_page_i | input | PAGE_W | Page just past the ring |
| rd_page_i | input | PAGE_W | Software read page |
| ptr_init_i | input | 1 | Load write page from start page |
| auto_recover_i | input | 1 | Roll back pointer on buffer full |
| imask_rx_i | input | 1 | Receive interrupt enable |
| imask_bf_i | input | 1 | Buffer-full interrupt enable |
| irq_clr_i | input | 2 | Write-one-to-clear for flags (0 rx, 1 full) |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_addr_o | output | PAGE_W+8 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| wr_page_o | output | PAGE_W | Current write page |
| last_status_o | output | 8 | Status of last stored frame |
| irq_rx_o | output | 1 | Receive interrupt flag |
| irq_bf_o | output | 1 | Buffer-full interrupt flag |

## Verification
The bench builds the block with PAGE_W=4, which gives a 4 KiB address space that a bench array can mirror byte for byte. After every frame, all 4096 locations are compared with an arithmetic model, so any stray write shows up. Three ring placements are swept against lengths that sit just below, on and above page-multiple boundaries; this reaches both end-to-start wrap paths and both alignment outcomes. Frames longer than the free space exercise the overflow stop, with recovery both enabled and disabled and with the read page at two different positions.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int OFF_W      = 8;
  localparam int DATA_OFF   = 4;
  localparam int DESC_PTR_W = 12;
  localparam int DESC_LEN_W = 12;
  localparam int ST_MC      = 0;
  localparam int ST_FO      = 1;
  localparam int ST_BF      = 2;
  localparam int IRQ_RX     = 0;
  localparam int IRQ_BF     = 1;
  localparam int N_IRQ      = 2;

  typedef enum logic [1:0] {WR_RX, WR_FIN, WR_DESC} wr_state_e;
endpackage

// File: rtl/rxring_page_step.sv
module rxring_page_step #(
  parameter int PAGE_W = 12
) (
  input  logic [PAGE_W-1:0] cur_i,
  input  logic [PAGE_W-1:0] first_i,
  input  logic [PAGE_W-1:0] limit_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] nxt_o
);
  logic [PAGE_W-1:0] inc;
  always_comb begin
    inc = cur_i + 1'b1;
    if (!step_i)             nxt_o = cur_i;
    else if (inc == limit_i) nxt_o = first_i;
    else                     nxt_o = inc;
  end
endmodule

// File: rtl/rxring_desc_mux.sv
module rxring_desc_mux
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 12
) (
  input  logic [1:0]            idx_i,
  input  logic [PAGE_W-1:0]     next_page_i,
  input  logic [DESC_LEN_W-1:0] len_i,
  input  logic [7:0]            status_i,
  output logic [7:0]            byte_o
);
  localparam int WORD_W = DESC_PTR_W + DESC_LEN_W + 8;
  logic [WORD_W-1:0] word;
  always_comb begin
    word   = {status_i, len_i, DESC_PTR_W'(next_page_i)};
    byte_o = word[idx_i*8 +: 8];
  end
endmodule

// File: rtl/rxring_irq_flags.sv
module rxring_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 12,
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic [PAGE_W-1:0] end_page_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic              ptr_init_i,
  input  logic              auto_recover_i,
  input  logic              imask_rx_i,
  input  logic              imask_bf_i,
  input  logic [1:0]        irq_clr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [7:0]        last_status_o,
  output logic              irq_rx_o,
  output logic              irq_bf_o
);
  wr_state_e             state_q;
  logic [1:0]            idx_q;
  logic                  in_frame_q, ovf_q, mc_q;
  logic [PAGE_W-1:0]     start_pg_q, wr_pg_q;
  logic [OFF_W-1:0]      off_q;
  logic [DESC_LEN_W-1:0] len_q;
  logic [7:0]            status_q;

  logic                  accept, first_byte, hit, align_need;
  logic [OFF_W-1:0]      off_nx;
  logic [PAGE_W-1:0]     pg_byte, pg_align, pg_final;
  logic [DESC_LEN_W-1:0] len4;
  logic [7:0]            status_w, desc_byte;
  logic [N_IRQ-1:0]      irq_set, irq_flags;

  assign accept     = in_valid_i && (state_q == WR_RX);
  assign first_byte = accept && !in_frame_q;
  assign off_nx     = off_q + 1'b1;
  assign len4       = len_q + DESC_LEN_W'(DATA_OFF);
  assign align_need = (len4[7:0] != 8'd0);

  rxring_page_step #(.PAGE_W(PAGE_W)) u_step_byte (
    .cur_i(wr_pg_q), .first_i(start_page_i), .limit_i(end_page_i),
    .step_i(off_q == {OFF_W{1'b1}}), .nxt_o(pg_byte)
  );

  rxring_page_step #(.PAGE_W(PAGE_W)) u_step_align (
    .cur_i(wr_pg_q), .first_i(start_page_i), .limit_i(end_page_i),
    .step_i(align_need), .nxt_o(pg_align)
  );

  // byte landing on offset 0 of the read page means the ring is full
  assign hit      = (off_nx == '0) && (pg_byte == rd_page_i);
  assign pg_final = (ovf_q && auto_recover_i) ? start_pg_q : pg_align;

  always_comb begin
    status_w        = '0;
    status_w[ST_MC] = mc_q;
    status_w[ST_FO] = ovf_q;
    status_w[ST_BF] = ovf_q;
  end

  rxring_desc_mux #(.PAGE_W(PAGE_W)) u_desc (
    .idx_i(idx_q), .next_page_i(wr_pg_q), .len_i(len4),
    .status_i(status_w), .byte_o(desc_byte)
  );

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      WR_RX: begin
        mem_we_o    = accept && !ovf_q;
        mem_addr_o  = {wr_pg_q, off_q};
        mem_wdata_o = in_data_i;
      end
      WR_DESC: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = {start_pg_q, {(OFF_W-2){1'b0}}, idx_q};
        mem_wdata_o = desc_byte;
      end
      default: ;
    endcase
  end

  always_comb begin
    irq_set         = '0;
    irq_set[IRQ_BF] = accept && !ovf_q && hit && imask_bf_i;
    irq_set[IRQ_RX] = (state_q == WR_DESC) && (idx_q == 2'd3) && imask_rx_i;
  end

  rxring_irq_flags #(.N(N_IRQ)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_set),
    .clr_i(irq_clr_i), .flag_o(irq_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= WR_RX;
      idx_q      <= '0;
      in_frame_q <= 1'b0;
      ovf_q      <= 1'b0;
      mc_q       <= 1'b0;
      start_pg_q <= '0;
      wr_pg_q    <= '0;
      off_q      <= OFF_W'(DATA_OFF);
      len_q      <= '0;
      status_q   <= '0;
    end else begin
      unique case (state_q)
        WR_RX: begin
          if (accept) begin
            in_frame_q <= 1'b1;
            if (first_byte) begin
              start_pg_q <= wr_pg_q;
              mc_q       <= in_data_i[0];
              len_q      <= DESC_LEN_W'(1);
            end else begin
              len_q      <= len_q + 1'b1;
            end
            if (!ovf_q) begin
              off_q   <= off_nx;
              wr_pg_q <= pg_byte;
              if (hit) ovf_q <= 1'b1;
            end
            if (in_last_i) state_q <= WR_FIN;
          end else if (ptr_init_i && !in_frame_q) begin
            wr_pg_q <= start_page_i;
          end
        end
        WR_FIN: begin
          wr_pg_q <= pg_final;
          idx_q   <= '0;
          state_q <= WR_DESC;
        end
        WR_DESC: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 2'd3) begin
            state_q    <= WR_RX;
            in_frame_q <= 1'b0;
            ovf_q      <= 1'b0;
            off_q      <= OFF_W'(DATA_OFF);
            status_q   <= status_w;
          end
        end
        default: state_q <= WR_RX;
      endcase
    end
  end

  assign in_ready_o    = (state_q == WR_RX);
  assign wr_page_o     = wr_pg_q;
  assign last_status_o = status_q;
  assign irq_rx_o      = irq_flags[IRQ_RX];
  assign irq_bf_o      = irq_flags[IRQ_BF];
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
  parameter int PAGE_W = 12,
  localparam int ADDR_W = PAGE_W + 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [PAGE_W-1:0] rd_page_i,
  input logic              imask_rx_i,
  input logic              imask_bf_i,
  input logic              irq_rx_o,
  input logic              irq_bf_o
);
  assert_no_read_page_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && in_ready_o && mem_addr_o[7:0] == 8'd0) |-> (mem_addr_o[ADDR_W-1:8] != rd_page_i));

  assert_desc_offsets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !in_ready_o) |-> (mem_addr_o[7:2] == 6'd0));

  assert_fin_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> !mem_we_o);

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |=> !in_ready_o);

  assert_rx_irq_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_rx_o) |-> $past(imask_rx_i));

  assert_bf_irq_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_bf_o) |-> $past(imask_bf_i));
endmodule

bind rxring_writer rxring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .rd_page_i(rd_page_i), .imask_rx_i(imask_rx_i),
  .imask_bf_i(imask_bf_i), .irq_rx_o(irq_rx_o), .irq_bf_o(irq_bf_o)
);

// File: tb/sim_rxring_writer.sv
module sim_rxring_writer;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 4;
  localparam int MEM = 1 << (PW + 8);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [7:0] in_data = 0;
  logic [PW-1:0] start_pg = 0, end_pg = 0, rd_pg = 0, wr_page;
  logic ptr_init = 0, auto_rec = 0, mask_rx = 0, mask_bf = 0;
  logic [1:0] irq_clr = 0;
  logic mem_we;
  logic [PW+7:0] mem_addr;
  logic [7:0] mem_wdata, last_status;
  logic irq_rx, irq_bf;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem [0:MEM-1];
  logic [7:0] exp_mem [0:MEM-1];
  int wp_model = 0, exp_st = 0;
  bit exp_irx = 0, exp_ibf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_writer #(.PAGE_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_ready_o(in_ready), .start_page_i(start_pg),
    .end_page_i(end_pg), .rd_page_i(rd_pg), .ptr_init_i(ptr_init),
    .auto_recover_i(auto_rec), .imask_rx_i(mask_rx), .imask_bf_i(mask_bf),
    .irq_clr_i(irq_clr), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .wr_page_o(wr_page), .last_status_o(last_status),
    .irq_rx_o(irq_rx), .irq_bf_o(irq_bf)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int adv(int p);
    int n = (p + 1) % (1 << PW);
    return (n == end_pg) ? int'(start_pg) : n;
  endfunction

  function automatic logic [7:0] pat(int i, int seed, bit mc);
    logic [7:0] v = 8'((i * 13 + seed) & 255);
    if (i == 0) v = {v[7:1], mc};
    return v;
  endfunction

  task automatic model_frame(int len, int seed, bit mc, output bit ov);
    int pg = wp_model, first_pg = wp_model, off = 4, len4;
    ov = 0;
    for (int i = 0; i < len; i++) begin
      if (!ov) begin
        exp_mem[pg*256 + off] = pat(i, seed, mc);
        if (off == 255) begin off = 0; pg = adv(pg); end else off++;
        if (off == 0 && pg == rd_pg) ov = 1;
      end
    end
    if (((len + 4) % 256) != 0) pg = adv(pg);
    if (ov && auto_rec) pg = first_pg;
    len4   = (len + 4) & 12'hFFF;
    exp_st = int'(mc) | (int'(ov) << 1) | (int'(ov) << 2);
    exp_mem[first_pg*256 + 0] = 8'(pg & 255);
    exp_mem[first_pg*256 + 1] = 8'(((len4 & 15) << 4) | ((pg >> 8) & 15));
    exp_mem[first_pg*256 + 2] = 8'((len4 >> 4) & 255);
    exp_mem[first_pg*256 + 3] = 8'(exp_st);
    wp_model = pg;
    exp_irx  = exp_irx | mask_rx;
    exp_ibf  = exp_ibf | (ov & mask_bf);
  endtask

  task automatic run_frame(string req, int len, int seed, bit mc);
    bit ov;
    int bad = 0, first_bad = -1;
    for (int a = 0; a < MEM; a++) exp_mem[a] = mem[a];
    model_frame(len, seed, mc, ov);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = pat(i, seed, mc); in_last = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk("R8", "ready low after last byte", int'(in_ready), 0);
    repeat (7) @(negedge clk);
    for (int a = 0; a < MEM; a++)
      if (mem[a] !== exp_mem[a]) begin bad++; if (first_bad < 0) first_bad = a; end
    chk(req, $sformatf("mem mismatches len=%0d (first addr %0h)", len, first_bad), bad, 0);
    chk("R5", $sformatf("write page len=%0d", len), int'(wr_page), wp_model);
    chk("R9", "last status", int'(last_status), exp_st);
    chk("R9", "rx irq flag", int'(irq_rx), int'(exp_irx));
    chk("R4", "bf irq flag", int'(irq_bf), int'(exp_ibf));
    chk("R8", "ready after descriptor", int'(in_ready), 1);
  endtask

  task automatic clear_irqs();
    @(negedge clk); irq_clr = 2'b11;
    @(negedge clk); irq_clr = 2'b00;
    exp_irx = 0; exp_ibf = 0;
    chk("R10", "flags cleared", int'({irq_rx, irq_bf}), 0);
  endtask

  task automatic set_ring(int s, int e);
    start_pg = PW'(s); end_pg = PW'(e);
    @(negedge clk); ptr_init = 1;
    @(negedge clk); ptr_init = 0;
    wp_model = s;
    chk("R2", "init loads start page", int'(wr_page), s);
  endtask

  initial begin
    int lens [7] = '{1, 60, 251, 252, 253, 508, 700};
    int rs [3] = '{2, 0, 5};
    int re [3] = '{6, 3, 15};
    int k = 0;
    bit ov;
    for (int a = 0; a < MEM; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "ready", int'(in_ready), 1);
    chk("R1", "write page", int'(wr_page), 0);
    chk("R1", "status/irqs", int'({last_status, irq_rx, irq_bf}), 0);
    chk("R1", "no write in reset", int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "no write idle", int'(mem_we), 0);
    mask_bf = 1;
    for (int c = 0; c < 3; c++) begin
      set_ring(rs[c], re[c]);
      for (int l = 0; l < 7; l++) begin
        rd_pg   = PW'(wp_model);
        mask_rx = (k % 3) != 0;
        run_frame((k % 2) ? "R7" : "R3", lens[l], k * 37, bit'(k % 2));
        k++;
      end
      clear_irqs();
    end
    // overflow cases on ring pages 2..5
    set_ring(2, 6);
    rd_pg = 2; auto_rec = 0; mask_rx = 1; mask_bf = 1;
    run_frame("R4", 1100, 5, 1);
    chk("R4", "overflow status bits", int'(last_status), 7);
    clear_irqs();
    rd_pg = PW'(wp_model); auto_rec = 1;
    run_frame("R6", 1100, 9, 0);
    chk("R6", "pointer rolled back", int'(wr_page), int'(rd_pg));
    clear_irqs();
    set_ring(2, 6);
    rd_pg = 4; auto_rec = 1; mask_bf = 0; mask_rx = 0;
    run_frame("R4", 600, 3, 0);
    chk("R4", "masked bf irq stays low", int'(irq_bf), 0);
    chk("R6", "rollback to frame page", int'(wr_page), 2);
    rd_pg = 4; auto_rec = 0; mask_bf = 1;
    model_frame(0, 0, 0, ov);  // placeholder discarded below
    wp_model = 2;
    exp_irx = 0;
    for (int a = 0; a < MEM; a++) exp_mem[a] = mem[a];
    run_frame("R4", 520, 11, 1);
    chk("R5", "no rollback without recovery", int'(wr_page), 5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule